// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block gathers eight active-low external interrupt lines and eight active-high internal level sources. It records each source in a pending vector. It combines that vector with per-source enable bits to form one maskable interrupt request to the processor core. External line 0 has its own non-maskable request output, which no enable bit can stop.

Each external line is resynchronized by a two-flop chain. Software picks, per line, whether the line is sensed on a falling edge or while it is held low. An edge-sensed pending bit stays set until software writes a 1 to it. A level-sensed bit tracks the line. Pending bits are set whether or not the source is enabled, so software can poll masked sources.

A per-line wake enable drives a combinational wake output whenever the core reports low-power mode and an enabled external line is pending. Software reaches three words over a simple 32-bit register bus (byte address bits 3:2 select the word):

- Word 0 is the pending vector. Bit 2n is external line n and bit 2n+1 is internal source n. Writing 1 clears edge-sensed external bits.
- Word 1 is the enable vector, in the same bit layout.
- Word 2 is the configuration word. Bits 7:0 are the per-line edge selects (1 = falling edge, 0 = low level). Bits 15:8 are the per-line wake enables.

Top module: `irq_pend_mask`

## Requirements
- R1: The enable word (address 0x4) holds bits 15:0 as written and reads as 0 after reset. Bit 2n enables external line n and bit 2n+1 enables internal source n.
- R2: Bits 31:16 of the enable word always read as 0, even after a write of all ones.
- R3: An external pending bit (pending word bit 2n) is set while its enable bit is clear, and core_irq stays low.
- R4: An enabled pending source other than external line 0 drives core_irq high.
- R5: With edge select bit n set (configuration word bit n = 1), a falling edge on line n sets pending bit 2n. The bit stays set after the line returns high, until a write of 1 to that bit.
- R6: With edge select bit n clear, pending bit 2n follows the synchronized line level. It is set 3 rising edges after the line goes low and clears 3 rising edges after the line goes high.
- R7: Internal source n sets pending bit 2n+1 one rising edge after int_lvl[n] rises. When enabled, it drives core_irq.
- R8: External line 0 drives core_nmi one rising edge after its pending bit sets, with its enable bit clear. It never drives core_irq.
- R9: wake is high when lp_mode is high and some external line n is pending with wake enable bit n (configuration word bit 8+n) set. It is low when lp_mode is low or no pending line has its wake enable set.
- R10: Writing 1 to a level-sensed pending bit has no effect, and the bit stays set while the line is low.
- R11: core_irq changes exactly one rising edge after the pending or enable change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 8 | External interrupt lines, active low, asynchronous |
| int_lvl | input | 8 | Internal level sources, active high, synchronous |
| lp_mode | input | 1 | Core is in low-power mode |
| reg_addr | input | 4 | Register byte address; bits 3:2 pick the word |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| core_irq | output | 1 | Registered maskable interrupt request |
| core_nmi | output | 1 | Registered non-maskable request from line 0 |
| wake | output | 1 | Combinational wake request |

## Verification
An external line change reaches the pending word on the third rising edge: two synchronizer stages, then the detect stage. An internal source reaches it on the first rising edge. core_irq and core_nmi follow one rising edge after pending or enable changes. Read data and wake follow pending at once. The bench drives every input on a falling edge, counts the exact number of rising edges to each result, and samples on the following falling edge. For the latency requirements it also checks that a result has not yet appeared one edge before it is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_n,
    output logic [N_LINES-1:0] active
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        typedef struct packed {
            logic s1;
            logic s2;
        } sync_t;

        sync_t st_d, st_q;

        always_comb begin
            st_d.s1 = line_n[i];
            st_d.s2 = st_q.s1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1};
            else        st_q <= st_d;
        end

        assign active[i] = ~st_q.s2;
    end
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] active,
    input  logic [N_LINES-1:0] edge_sel,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_det
        typedef struct packed {
            logic prev;
            logic pend;
        } det_t;

        det_t st_d, st_q;
        logic fall;

        always_comb begin
            fall      = active[i] & ~st_q.prev;
            st_d.prev = active[i];
            if (edge_sel[i]) st_d.pend = (st_q.pend & ~clr[i]) | fall;
            else             st_d.pend = active[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign pend[i] = st_q.pend;

        // R5: a detected fall in edge mode sets pending
        a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[i] && active[i] && !st_q.prev) |=> pend[i]);
        // R5: edge-mode pending holds without a clear
        a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[i] && pend[i] && !clr[i]) |=> pend[i]);
        // R6, R10: level-mode pending tracks the synchronized line
        a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_sel[i]) |=> (pend[i] == $past(active[i])));
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [2*N_LINES-1:0] pend_word,
    output logic [2*N_LINES-1:0] mask,
    output logic [N_LINES-1:0]   edge_sel,
    output logic [N_LINES-1:0]   wake_en,
    output logic [N_LINES-1:0]   clr,
    output logic [DATA_W-1:0]    rdata
);
    localparam int unsigned MW = 2 * N_LINES;

    typedef struct packed {
        logic [MW-1:0]      mask;
        logic [N_LINES-1:0] edge_sel;
        logic [N_LINES-1:0] wake_en;
    } cfg_t;

    cfg_t     st_d, st_q;
    reg_sel_e sel;
    logic     unused_bits;

    assign sel         = reg_sel_e'(addr[3:2]);
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:MW]};

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel)
                SEL_MASK: st_d.mask = wdata[MW-1:0];
                SEL_CFG: begin
                    st_d.edge_sel = wdata[N_LINES-1:0];
                    st_d.wake_en  = wdata[MW-1:N_LINES];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int n = 0; n < N_LINES; n++) begin
            clr[n] = we && (sel == SEL_PEND) && wdata[2*n];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_PEND: rdata[MW-1:0] = pend_word;
            SEL_MASK: rdata[MW-1:0] = st_q.mask;
            SEL_CFG:  rdata[MW-1:0] = {st_q.wake_en, st_q.edge_sel};
            default:  rdata = '0;
        endcase
    end

    assign mask     = st_q.mask;
    assign edge_sel = st_q.edge_sel;
    assign wake_en  = st_q.wake_en;

    // R1: a write to the enable word lands on the next edge
    a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MASK) |=> (mask == $past(wdata[MW-1:0])));
    // R1: the enable word changes only through a write
    a_r1_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_MASK) |=> $stable(mask));
endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask
    import irq_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ext_irq_n,
    input  logic [N_LINES-1:0] int_lvl,
    input  logic               lp_mode,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               core_irq,
    output logic               core_nmi,
    output logic               wake
);
    localparam int unsigned MW = 2 * N_LINES;

    typedef struct packed {
        logic [N_LINES-1:0] int_pend;
        logic               irq;
        logic               nmi;
    } req_t;

    req_t st_d, st_q;

    logic [N_LINES-1:0] ext_active, ext_pend, edge_sel, wake_en, clr;
    logic [MW-1:0]      pend_word, mask, maskable;

    irq_sync #(.N_LINES(N_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (ext_irq_n),
        .active (ext_active)
    );

    irq_detect #(.N_LINES(N_LINES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (ext_active),
        .edge_sel (edge_sel),
        .clr      (clr),
        .pend     (ext_pend)
    );

    for (genvar n = 0; n < N_LINES; n++) begin : g_word
        assign pend_word[2*n]   = ext_pend[n];
        assign pend_word[2*n+1] = st_q.int_pend[n];
    end

    irq_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .pend_word (pend_word),
        .mask      (mask),
        .edge_sel  (edge_sel),
        .wake_en   (wake_en),
        .clr       (clr),
        .rdata     (reg_rdata)
    );

    assign maskable = pend_word & mask & ~MW'(1);

    always_comb begin
        st_d.int_pend = int_lvl;
        st_d.irq      = |maskable;
        st_d.nmi      = ext_pend[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_irq = st_q.irq;
    assign core_nmi = st_q.nmi;
    assign wake     = lp_mode & |(ext_pend & wake_en);

    // R8: line 0 pending raises the non-maskable request next cycle
    a_r8_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pend[0] |=> core_nmi);
    // R4, R11: an enabled pending source raises core_irq next cycle
    a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|maskable) |=> core_irq);
    // R3, R8: no enabled pending source leaves core_irq low next cycle
    a_r3_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|maskable) |=> !core_irq);
    // R7: internal pending tracks the source one edge later
    a_r7_int_pend: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.int_pend == $past(int_lvl)));
    // R9: wake never asserts outside low-power mode
    a_r9_wake_lp: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> lp_mode);
endmodule

// File: tb/irq_pend_mask_test.sv
module irq_pend_mask_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_irq_n = 8'hFF;
    logic [7:0]  int_lvl = 8'h00;
    logic        lp_mode = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        core_irq, core_nmi, wake;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_PEND = 4'h0, A_MASK = 4'h4, A_CFG = 4'h8;

    always #5 clk = ~clk;

    irq_pend_mask uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_irq_n (ext_irq_n),
        .int_lvl   (int_lvl),
        .lp_mode   (lp_mode),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .core_irq  (core_irq),
        .core_nmi  (core_nmi),
        .wake      (wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_MASK, v); check("R1 mask reset", v, 32'h0);
        rd(A_PEND, v); check("R1 pend reset", v, 32'h0);
        rd(A_CFG, v);  check("R1 cfg reset", v, 32'h0);
        check("R1 irq reset", {31'b0, core_irq}, 32'h0);
        check("R8 nmi reset", {31'b0, core_nmi}, 32'h0);
        check("R9 wake reset", {31'b0, wake}, 32'h0);
    endtask

    task automatic t_mask_rw;
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R2 upper bits zero", v, 32'h0000_FFFF);
        wr(A_MASK, 32'h0000_A5C3);
        rd(A_MASK, v); check("R1 mask holds write", v, 32'h0000_A5C3);
        wr(A_MASK, 32'h0);
        tick(1);
    endtask

    task automatic t_level;
        logic [31:0] v;
        ext_irq_n[3] = 1'b0;
        tick(2);
        rd(A_PEND, v); check("R6 level not yet at edge 2", v, 32'h0);
        tick(1);
        rd(A_PEND, v); check("R3 R6 pending while masked", v, 32'h40);
        tick(1);
        check("R3 irq stays low masked", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h40);
        check("R11 irq not yet on mask edge", {31'b0, core_irq}, 32'h0);
        tick(1);
        check("R4 R11 irq one edge after mask", {31'b0, core_irq}, 32'h1);
        wr(A_PEND, 32'h40);
        rd(A_PEND, v); check("R10 clear ignored on level bit", v, 32'h40);
        ext_irq_n[3] = 1'b1;
        tick(2);
        rd(A_PEND, v); check("R6 still set at edge 2", v, 32'h40);
        tick(1);
        rd(A_PEND, v); check("R6 level clears at edge 3", v, 32'h0);
        check("R11 irq still high", {31'b0, core_irq}, 32'h1);
        tick(1);
        check("R11 irq drops one edge later", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(A_CFG, 32'h4);
        ext_irq_n[2] = 1'b0;
        tick(3);
        rd(A_PEND, v); check("R5 edge sets pending", v, 32'h10);
        ext_irq_n[2] = 1'b1;
        tick(6);
        rd(A_PEND, v); check("R5 pending held after release", v, 32'h10);
        wr(A_PEND, 32'h10);
        rd(A_PEND, v); check("R5 write one clears", v, 32'h0);
        tick(4);
        rd(A_PEND, v); check("R5 no retrigger while high", v, 32'h0);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_nmi;
        logic [31:0] v;
        ext_irq_n[0] = 1'b0;
        tick(3);
        rd(A_PEND, v); check("R8 line0 pending", v, 32'h1);
        check("R8 nmi not yet", {31'b0, core_nmi}, 32'h0);
        tick(1);
        check("R8 nmi with mask clear", {31'b0, core_nmi}, 32'h1);
        check("R8 no maskable irq", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h1);
        tick(1);
        check("R8 mask bit0 ignored for irq", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h0);
        ext_irq_n[0] = 1'b1;
        tick(4);
        check("R8 nmi drops", {31'b0, core_nmi}, 32'h0);
    endtask

    task automatic t_wake;
        wr(A_CFG, 32'h200);
        lp_mode = 1'b1;
        ext_irq_n[1] = 1'b0;
        tick(3);
        check("R9 wake in low power", {31'b0, wake}, 32'h1);
        lp_mode = 1'b0;
        #1 check("R9 no wake out of low power", {31'b0, wake}, 32'h0);
        lp_mode = 1'b1;
        wr(A_CFG, 32'h0);
        check("R9 no wake when disabled", {31'b0, wake}, 32'h0);
        lp_mode = 1'b0;
        ext_irq_n[1] = 1'b1;
        tick(4);
    endtask

    task automatic t_internal;
        logic [31:0] v;
        int_lvl[5] = 1'b1;
        tick(1);
        rd(A_PEND, v); check("R7 internal pending", v, 32'h800);
        check("R7 masked internal no irq", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h800);
        tick(1);
        check("R7 internal irq enabled", {31'b0, core_irq}, 32'h1);
        int_lvl[5] = 1'b0;
        tick(1);
        rd(A_PEND, v); check("R7 internal clears", v, 32'h0);
        tick(1);
        check("R7 irq drops", {31'b0, core_irq}, 32'h0);
        wr(A_MASK, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mask_rw();
        t_level();
        t_edge();
        t_nmi();
        t_wake();
        t_internal();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule